// File: doc/BRIEF.md
# Byte/Word Arithmetic-Logic Unit with Status Flags

This block is the purely combinational execution stage of a 16-bit microcontroller datapath. In the same cycle it takes a destination operand, a source operand, an operation code, a size select and the current carry, zero, negative and overflow bits. It returns the operation result, a fresh set of the four status flags, and two enables. One enable says whether the result is to be written back. The other says whether the flags are to be written back. Operand fetch, memory traffic and the register file sit outside the block.

Subtraction uses the add-the-complement form, so a carry of one means no borrow took place. A packed-decimal add carries digit by digit. The logical operations report "result non-zero" on the carry flag. Each operation can run on the low byte or on the full word. In byte mode the sign, zero and carry all come from the low eight bits. One-operand operations act on the destination operand and take no notice of the source.

There is no data stream at the edge of this block, so it has no valid/ready handshake. All pins are plain combinational control and data.

Top module: `byte_word_alu`

## Requirements
- R1: The operation code `op_i` uses this encoding: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-carry, 4 compare, 5 decimal add, 6 and, 7 bit test, 8 bit clear, 9 bit set, 10 xor, 11 rotate right through carry, 12 byte swap, 13 arithmetic shift right, 14 sign extend. Any other code gives a zero result, deasserts both write enables, and passes the incoming flags straight through.
- R2: Add gives dst+src, and add-with-carry gives dst+src+`c_i`. C is set when the unmasked sum does not fit in the selected width (8 or 16 bits).
- R3: Subtract and compare compute dst + (~src limited to the width) + 1. Subtract-with-carry uses `c_i` in place of the 1, so C=1 means no borrow. Compare updates the flags but holds `res_we_o` low.
- R4: For add, add-with-carry, subtract, subtract-with-carry and compare, V is set exactly when the signed result overflows the selected width.
- R5: Every operation that writes flags takes N from the sign bit of the result at its width (bit 7 in byte mode, bit 15 otherwise) and sets Z when all bits inside that width are zero.
- R6: Decimal add treats the operands as packed BCD (four digits for a word, two for a byte) and adds them with `c_i`. C is set when the decimal sum exceeds 9999 (word) or 99 (byte), and V is cleared.
- R7: And and bit test produce dst & src, set C to "result non-zero" and clear V. Bit test holds `res_we_o` low.
- R8: Xor sets C to "result non-zero" and sets V only when the sign bits of both operands are set.
- R9: Bit clear (dst & ~src) and bit set (dst | src) write the result but hold `flag_we_o` low, and the flag outputs equal the incoming flags.
- R10: Rotate right through carry shifts dst right by one at the selected width. It puts the old `c_i` into that width's MSB and the old LSB into C, and clears V.
- R11: Arithmetic shift right shifts dst right by one at the selected width and keeps its sign bit. The old LSB goes to C and V is cleared.
- R12: Byte swap always exchanges the two bytes of the full 16-bit dst, whatever the size select. It does not write flags.
- R13: Sign extend copies dst bit 7 into bits 15..8 whatever the size select. N comes from bit 15, C is "result non-zero", and V is cleared.
- R14: In byte mode, result bits 15..8 are zero for every operation except byte swap and sign extend, whatever dst[15:8] and src[15:8] hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dst_i | input | 16 | Destination operand (the only operand of one-operand operations) |
| src_i | input | 16 | Source operand |
| op_i | input | 5 | Operation code (encoding in R1) |
| byte_i | input | 1 | 1 selects byte width, 0 selects word width |
| c_i | input | 1 | Incoming carry flag |
| z_i | input | 1 | Incoming zero flag |
| n_i | input | 1 | Incoming negative flag |
| v_i | input | 1 | Incoming overflow flag |
| res_o | output | 16 | Operation result |
| res_we_o | output | 1 | Result is to be written back |
| flag_we_o | output | 1 | Flags are to be written back |
| c_o | output | 1 | New carry flag |
| z_o | output | 1 | New zero flag |
| n_o | output | 1 | New negative flag |
| v_o | output | 1 | New overflow flag |

## Verification
The hardest cases to reach are byte-mode operations whose upper operand bytes are deliberately non-zero. A wrong width choice would go unseen with clean operands, so the stimulus loads junk into bits 15..8 and uses low bytes that carry, borrow or shift out exactly at bit 7. The decimal carry chain is driven end to end with 0x9999 + 1, and once more in byte mode with an incoming carry, so that every digit stage has to ripple. The operations that must leave the flags alone are run with unusual incoming flag patterns, so that any write to the flags shows up as a change at the outputs.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADDC = 5'd1,
    OP_SUB  = 5'd2,
    OP_SUBC = 5'd3,
    OP_CMP  = 5'd4,
    OP_DADD = 5'd5,
    OP_AND  = 5'd6,
    OP_BIT  = 5'd7,
    OP_BIC  = 5'd8,
    OP_BIS  = 5'd9,
    OP_XOR  = 5'd10,
    OP_RRC  = 5'd11,
    OP_SWPB = 5'd12,
    OP_RRA  = 5'd13,
    OP_SXT  = 5'd14
  } alu_op_e;

  typedef struct packed {
    logic v;
    logic n;
    logic z;
    logic c;
  } alu_flags_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              inv_b_i,
  input  logic              cin_i,
  input  logic              byte_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o,
  output logic              ovf_o
);
  localparam int HI_W = DATA_W - BYTE_W;

  logic [DATA_W-1:0] a_m, b_x, b_m;
  logic [DATA_W:0]   wide;
  logic              sa, sb, sr;

  always_comb begin
    b_x = inv_b_i ? ~b_i : b_i;
    a_m = byte_i ? {{HI_W{1'b0}}, a_i[BYTE_W-1:0]} : a_i;
    b_m = byte_i ? {{HI_W{1'b0}}, b_x[BYTE_W-1:0]} : b_x;
    wide = {1'b0, a_m} + {1'b0, b_m} + {{DATA_W{1'b0}}, cin_i};
    if (byte_i) begin
      sum_o  = {{HI_W{1'b0}}, wide[BYTE_W-1:0]};
      cout_o = wide[BYTE_W];
      sa     = a_m[BYTE_W-1];
      sb     = b_m[BYTE_W-1];
      sr     = wide[BYTE_W-1];
    end else begin
      sum_o  = wide[DATA_W-1:0];
      cout_o = wide[DATA_W];
      sa     = a_m[DATA_W-1];
      sb     = b_m[DATA_W-1];
      sr     = wide[DATA_W-1];
    end
    ovf_o = (sa == sb) && (sr != sa);
  end

  // R2: a plain add that carries out must wrap below its first operand
  always_comb begin
    if (!$isunknown({a_i, b_i, inv_b_i, cin_i, byte_i})) begin
      if (!inv_b_i && !cin_i && cout_o) begin
        p_carry_wraps_r2: assert (sum_o < a_m)
          else $error("carry without wrap");
      end
    end
  end

endmodule

// File: rtl/alu_bcd_add.sv
module alu_bcd_add #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              byte_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o
);
  localparam int DIGITS  = DATA_W / 4;
  localparam int BDIGITS = BYTE_W / 4;
  localparam int HI_W    = DATA_W - BYTE_W;

  logic [DIGITS:0]   chain;
  logic [DATA_W-1:0] raw;

  assign chain[0] = cin_i;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    logic [4:0] dsum;
    logic [4:0] dfix;
    always_comb begin
      dsum = {1'b0, a_i[4*d +: 4]} + {1'b0, b_i[4*d +: 4]} + {4'd0, chain[d]};
      dfix = dsum - 5'd10;
    end
    assign chain[d+1]  = (dsum > 5'd9);
    assign raw[4*d +: 4] = chain[d+1] ? dfix[3:0] : dsum[3:0];

    // R6: valid decimal digits in give a valid decimal digit out
    always_comb begin
      if (!$isunknown({a_i[4*d +: 4], b_i[4*d +: 4], chain[d]})) begin
        if (a_i[4*d +: 4] <= 4'd9 && b_i[4*d +: 4] <= 4'd9) begin
          p_digit_valid_r6: assert (raw[4*d +: 4] <= 4'd9)
            else $error("decimal digit out of range");
        end
      end
    end
  end

  assign sum_o  = byte_i ? {{HI_W{1'b0}}, raw[BYTE_W-1:0]} : raw;
  assign cout_o = byte_i ? chain[BDIGITS] : chain[DIGITS];

endmodule

// File: rtl/alu_shift_logic.sv
module alu_shift_logic
  import alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic              cin_i,
  input  logic              byte_i,
  output logic [DATA_W-1:0] res_o,
  output logic              out_bit_o
);
  localparam int HI_W = DATA_W - BYTE_W;

  logic [DATA_W-1:0] raw;
  logic              top_in;

  always_comb begin
    top_in    = 1'b0;
    out_bit_o = dst_i[0];
    raw       = '0;
    unique case (op_i)
      OP_AND, OP_BIT: raw = dst_i & src_i;
      OP_BIC:         raw = dst_i & ~src_i;
      OP_BIS:         raw = dst_i | src_i;
      OP_XOR:         raw = dst_i ^ src_i;
      OP_RRC, OP_RRA: begin
        if (op_i == OP_RRC) top_in = cin_i;
        else top_in = byte_i ? dst_i[BYTE_W-1] : dst_i[DATA_W-1];
        raw = dst_i >> 1;
        if (byte_i) begin
          raw[DATA_W-1:BYTE_W-1] = '0;
          raw[BYTE_W-1] = top_in;
        end else begin
          raw[DATA_W-1] = top_in;
        end
      end
      OP_SWPB: raw = {dst_i[BYTE_W-1:0], dst_i[DATA_W-1:BYTE_W]};
      OP_SXT:  raw = {{HI_W{dst_i[BYTE_W-1]}}, dst_i[BYTE_W-1:0]};
      default: raw = '0;
    endcase
    if (byte_i && op_i != OP_SWPB && op_i != OP_SXT)
      res_o = {{HI_W{1'b0}}, raw[BYTE_W-1:0]};
    else
      res_o = raw;
  end

endmodule

// File: rtl/byte_word_alu.sv
module byte_word_alu
  import alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [4:0]        op_i,
  input  logic              byte_i,
  input  logic              c_i,
  input  logic              z_i,
  input  logic              n_i,
  input  logic              v_i,
  output logic [DATA_W-1:0] res_o,
  output logic              res_we_o,
  output logic              flag_we_o,
  output logic              c_o,
  output logic              z_o,
  output logic              n_o,
  output logic              v_o
);
  localparam int HI_W = DATA_W - BYTE_W;

  alu_op_e           op;
  logic              is_arith, is_sub, arith_cin;
  logic [DATA_W-1:0] add_res, bcd_res, sl_res;
  logic              add_c, add_v, bcd_c, sl_bit;
  logic              narrow, sign_bit, all_zero;
  alu_flags_t        f_in, f_new;

  assign op   = alu_op_e'(op_i);
  assign f_in = '{v: v_i, n: n_i, z: z_i, c: c_i};

  always_comb begin
    is_arith  = 1'b0;
    is_sub    = 1'b0;
    arith_cin = 1'b0;
    case (op)
      OP_ADD:  is_arith = 1'b1;
      OP_ADDC: begin is_arith = 1'b1; arith_cin = c_i; end
      OP_SUB, OP_CMP: begin is_arith = 1'b1; is_sub = 1'b1; arith_cin = 1'b1; end
      OP_SUBC: begin is_arith = 1'b1; is_sub = 1'b1; arith_cin = c_i; end
      default: ;
    endcase
  end

  alu_addsub #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_addsub (
    .a_i(dst_i), .b_i(src_i), .inv_b_i(is_sub), .cin_i(arith_cin),
    .byte_i(byte_i), .sum_o(add_res), .cout_o(add_c), .ovf_o(add_v)
  );

  alu_bcd_add #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_bcd (
    .a_i(dst_i), .b_i(src_i), .cin_i(c_i), .byte_i(byte_i),
    .sum_o(bcd_res), .cout_o(bcd_c)
  );

  alu_shift_logic #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_shl (
    .op_i(op), .dst_i(dst_i), .src_i(src_i), .cin_i(c_i), .byte_i(byte_i),
    .res_o(sl_res), .out_bit_o(sl_bit)
  );

  always_comb begin
    res_o     = '0;
    res_we_o  = 1'b0;
    flag_we_o = 1'b0;
    if (is_arith) begin
      res_o     = add_res;
      res_we_o  = (op != OP_CMP);
      flag_we_o = 1'b1;
    end else begin
      case (op)
        OP_DADD: begin res_o = bcd_res; res_we_o = 1'b1; flag_we_o = 1'b1; end
        OP_BIT:  begin res_o = sl_res; flag_we_o = 1'b1; end
        OP_AND, OP_XOR, OP_RRC, OP_RRA, OP_SXT: begin
          res_o = sl_res; res_we_o = 1'b1; flag_we_o = 1'b1;
        end
        OP_BIC, OP_BIS, OP_SWPB: begin res_o = sl_res; res_we_o = 1'b1; end
        default: ;
      endcase
    end
  end

  always_comb begin
    narrow   = byte_i && (op != OP_SXT);
    sign_bit = narrow ? res_o[BYTE_W-1] : res_o[DATA_W-1];
    all_zero = narrow ? (res_o[BYTE_W-1:0] == '0) : (res_o == '0);
    f_new    = '{v: 1'b0, n: sign_bit, z: all_zero, c: 1'b0};
    case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
        f_new.c = add_c;
        f_new.v = add_v;
      end
      OP_DADD: f_new.c = bcd_c;
      OP_AND, OP_BIT, OP_SXT: f_new.c = !all_zero;
      OP_XOR: begin
        f_new.c = !all_zero;
        f_new.v = narrow ? (dst_i[BYTE_W-1] & src_i[BYTE_W-1])
                         : (dst_i[DATA_W-1] & src_i[DATA_W-1]);
      end
      OP_RRC, OP_RRA: f_new.c = sl_bit;
      default: ;
    endcase
    if (!flag_we_o) f_new = f_in;
  end

  assign {v_o, n_o, z_o, c_o} = f_new;

  always_comb begin
    if (!$isunknown({dst_i, src_i, op_i, byte_i, c_i, z_i, n_i, v_i})) begin
      if (byte_i && op != OP_SWPB && op != OP_SXT) begin
        p_byte_upper_zero_r14: assert (res_o[DATA_W-1:BYTE_W] == {HI_W{1'b0}})
          else $error("upper byte not cleared");
      end
      if (!flag_we_o) begin
        p_flags_kept_r9: assert ({v_o, n_o, z_o, c_o} == {v_i, n_i, z_i, c_i})
          else $error("flags changed without write");
      end
      if (op_i > 5'd14) begin
        p_bad_code_r1: assert (res_o == '0 && !res_we_o && !flag_we_o)
          else $error("unused code had effect");
      end
      if (op == OP_CMP || op == OP_BIT) begin
        p_test_only_r3: assert (!res_we_o && flag_we_o)
          else $error("test operation wrote result");
      end
    end
  end

endmodule

// File: tb/test_byte_word_alu.sv
module test_byte_word_alu;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [15:0] dst, src, res;
  logic [4:0]  op;
  logic        bm, ci, zi, ni, vi;
  logic        rwe, fwe, co, zo, no, vo;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  byte_word_alu i_byte_word_alu (
    .dst_i(dst), .src_i(src), .op_i(op), .byte_i(bm),
    .c_i(ci), .z_i(zi), .n_i(ni), .v_i(vi),
    .res_o(res), .res_we_o(rwe), .flag_we_o(fwe),
    .c_o(co), .z_o(zo), .n_o(no), .v_o(vo)
  );

  // flags packed as {v,n,z,c}
  task automatic run(input string tag, input logic [4:0] o, input logic b,
                     input logic [15:0] d, input logic [15:0] s,
                     input logic [3:0] fin, input logic [15:0] er,
                     input logic erwe, input logic efwe, input logic [3:0] ef);
    logic [21:0] got, exp;
    @(negedge clk);
    op = o; bm = b; dst = d; src = s;
    {vi, ni, zi, ci} = fin;
    #2;
    got = {res, rwe, fwe, vo, no, zo, co};
    exp = {er, erwe, efwe, ef};
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got res=%h rwe=%b fwe=%b vnzc=%b, expected res=%h rwe=%b fwe=%b vnzc=%b",
               tag, got[21:6], got[5], got[4], got[3:0],
               exp[21:6], exp[5], exp[4], exp[3:0]);
    end
  endtask

  task automatic t_reset;
    run("R5 idle add zero", 5'd0, 1'b0, 16'h0000, 16'h0000, 4'b0000,
        16'h0000, 1, 1, 4'b0010);
  endtask

  task automatic t_add;
    run("R4 add signed overflow", 5'd0, 0, 16'h7FFF, 16'h0001, 4'b0000, 16'h8000, 1, 1, 4'b1100);
    run("R2 add carry out word",  5'd0, 0, 16'hFFFF, 16'h0001, 4'b0000, 16'h0000, 1, 1, 4'b0011);
    run("R2 add byte carry R14",  5'd0, 1, 16'h12FF, 16'h3401, 4'b0000, 16'h0000, 1, 1, 4'b0011);
    run("R2 addc uses c_i",       5'd1, 0, 16'h0001, 16'h0002, 4'b0001, 16'h0004, 1, 1, 4'b0000);
  endtask

  task automatic t_sub;
    run("R3 sub no borrow",       5'd2, 0, 16'h0005, 16'h0003, 4'b0000, 16'h0002, 1, 1, 4'b0001);
    run("R3 sub borrow",          5'd2, 0, 16'h0003, 16'h0005, 4'b0000, 16'hFFFE, 1, 1, 4'b0100);
    run("R4 sub signed overflow", 5'd2, 0, 16'h8000, 16'h0001, 4'b0000, 16'h7FFF, 1, 1, 4'b1001);
    run("R3 subc with c_i=0",     5'd3, 0, 16'h0005, 16'h0003, 4'b0000, 16'h0001, 1, 1, 4'b0001);
    run("R3 cmp byte equal",      5'd4, 1, 16'hAA42, 16'h5542, 4'b0000, 16'h0000, 0, 1, 4'b0011);
  endtask

  task automatic t_dadd;
    run("R6 dadd word",           5'd5, 0, 16'h1234, 16'h5678, 4'b0000, 16'h6912, 1, 1, 4'b0000);
    run("R6 dadd full ripple",    5'd5, 0, 16'h9999, 16'h0001, 4'b0000, 16'h0000, 1, 1, 4'b0011);
    run("R6 dadd byte with c_i",  5'd5, 1, 16'h0099, 16'h0001, 4'b0001, 16'h0001, 1, 1, 4'b0001);
  endtask

  task automatic t_logic;
    run("R7 and nonzero",         5'd6, 0, 16'hF0F0, 16'h8F00, 4'b0000, 16'h8000, 1, 1, 4'b0101);
    run("R7 bit test zero",       5'd7, 0, 16'h00FF, 16'h0F00, 4'b1101, 16'h0000, 0, 1, 4'b0010);
    run("R8 xor both signs",      5'd10, 0, 16'h8001, 16'h8003, 4'b0000, 16'h0002, 1, 1, 4'b1001);
    run("R8 xor byte one sign",   5'd10, 1, 16'h0080, 16'h0001, 4'b0000, 16'h0081, 1, 1, 4'b0101);
  endtask

  task automatic t_bic_bis;
    run("R9 bic keeps flags",     5'd8, 0, 16'hFFFF, 16'h0F0F, 4'b1010, 16'hF0F0, 1, 0, 4'b1010);
    run("R9 bis keeps flags",     5'd9, 0, 16'h1000, 16'h0001, 4'b0101, 16'h1001, 1, 0, 4'b0101);
  endtask

  task automatic t_shift;
    run("R10 rrc word",           5'd11, 0, 16'h0001, 16'h1234, 4'b0001, 16'h8000, 1, 1, 4'b0101);
    run("R10 rrc byte R14",       5'd11, 1, 16'hAB02, 16'h0000, 4'b0000, 16'h0001, 1, 1, 4'b0000);
    run("R11 rra word",           5'd13, 0, 16'h8003, 16'h0000, 4'b0000, 16'hC001, 1, 1, 4'b0101);
    run("R11 rra byte",           5'd13, 1, 16'h7781, 16'h0000, 4'b0000, 16'h00C0, 1, 1, 4'b0101);
  endtask

  task automatic t_swap_sext;
    run("R12 swpb in byte mode",  5'd12, 1, 16'h12AB, 16'h0000, 4'b0000, 16'hAB12, 1, 0, 4'b0000);
    run("R13 sxt negative",       5'd14, 1, 16'h1280, 16'h0000, 4'b0000, 16'hFF80, 1, 1, 4'b0101);
    run("R13 sxt to zero",        5'd14, 0, 16'hFF00, 16'h0000, 4'b0000, 16'h0000, 1, 1, 4'b0010);
  endtask

  task automatic t_invalid;
    run("R1 unused code 20",      5'd20, 0, 16'h1234, 16'h5678, 4'b1111, 16'h0000, 0, 0, 4'b1111);
    run("R1 unused code 31",      5'd31, 1, 16'hFFFF, 16'hFFFF, 4'b0000, 16'h0000, 0, 0, 4'b0000);
  endtask

  initial begin
    dst = '0; src = '0; op = '0; bm = 0; ci = 0; zi = 0; ni = 0; vi = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset();
    t_add();
    t_sub();
    t_dadd();
    t_logic();
    t_bic_bis();
    t_shift();
    t_swap_sext();
    t_invalid();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got running, expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule